// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer Core

This block is a seconds-granularity watchdog that a host programs through a byte-wide register port. The port has an address, a write strobe with write data, and a read strobe whose data comes back one cycle later. The countdown advances on an external one-second tick. The length of the reset pulse it produces is measured in external one-millisecond ticks. Both tick inputs are single-cycle strobes from a shared timebase elsewhere on the chip.

The run state has three values. A freshly reset core sits in a never-configured state until the host writes it. The host then either arms the watchdog, which loads the countdown from the timeout register, or parks it stopped, which freezes the count and masks expiry. While armed, the host keeps it alive by writing a zero to the ping register. If the count runs out, the core drives its reset output for the programmed number of milliseconds, latches the expiry code in the cause register, and drops back to stopped. The host can read the seconds remaining at any time.

A host write that lands in the same cycle as the final second tick is honoured, and expiry is suppressed. This prevents a keep-alive that arrives just in time from being lost.

Top module: `wdt_regcore`

## Requirements
- R1: After reset the state reads 0 (never configured), the cause reads 0 (power cycle), the timeout reads 30, time left reads 30, the pulse length reads DUR_DEF (default 10), and the reset output is low.
- R2: A read strobe returns data on the following cycle. The addresses are: 0x05 cause, 0x06 state, 0x07 timeout, 0x08 seconds left, 0x09 ping (reads 0), 0x0A pulse length in milliseconds. Any other address reads 0.
- R3: A timeout write (0x07) of 3 to 255 is stored. Any other value is ignored and the old value is kept.
- R4: A pulse-length write (0x0A) of 1 to 255 is stored, and a write of 0 is ignored. The length in force when a pulse starts applies to the whole of that pulse.
- R5: Writing 2 to the state register (0x06) arms the watchdog (state reads 2) and loads the seconds left from the timeout. Writing 1 stops it (state reads 1), which freezes the seconds left. Other state values are ignored.
- R6: While armed, each second tick lowers the seconds left by one. While stopped or never configured, second ticks leave it unchanged.
- R7: While armed, a write of 0x00 to the ping register (0x09) reloads the seconds left from the timeout. A ping with any non-zero value has no effect.
- R8: A second tick that finds the core armed with one second left expires it. In the next cycle the reset output is high, the state reads 1, the cause reads 1 (watchdog expiry), and the seconds left read 0.
- R9: The reset output stays high until the number of millisecond ticks equal to the latched pulse length has been seen. It is low from the cycle after the last of those ticks.
- R10: A zero ping, or a state write of 1 or 2, that arrives in the same cycle as an expiring second tick takes precedence. No pulse starts and the cause is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe per second |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| addr | input | AW (8) | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW (8) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW (8) | Read data, valid the cycle after rd_en |
| wdt_rst_o | output | 1 | Registered reset pulse output |

## Verification
The countdown's final second tick and a host write can fall in the same cycle. The bench provokes this twice: a zero ping and a stop command are each driven on the same clock edge as the tick that finds one second left. The bench judges the result by reading back state, seconds left and cause, and by confirming that the reset output never rose. A normal expiry is also run, so that the same edge without a host write is seen to produce the pulse, the cause code and the stopped state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WS_INIT = 2'd0,
    WS_STOP = 2'd1,
    WS_RUN  = 2'd2
  } wdt_state_e;

  localparam logic [7:0] A_CAUSE = 8'h05;
  localparam logic [7:0] A_STATE = 8'h06;
  localparam logic [7:0] A_TMO   = 8'h07;
  localparam logic [7:0] A_LEFT  = 8'h08;
  localparam logic [7:0] A_PING  = 8'h09;
  localparam logic [7:0] A_DUR   = 8'h0A;

  localparam logic [7:0] CAUSE_POWER  = 8'd0;
  localparam logic [7:0] CAUSE_EXPIRY = 8'd1;
endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg #(
  parameter int DW      = 8,
  parameter int TMO_MIN = 3,
  parameter int TMO_DEF = 30,
  parameter int DUR_DEF = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tmo_we,
  input  logic          dur_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] tmo_q,
  output logic [DW-1:0] dur_q
);
  localparam logic [DW-1:0] TMO_LO = DW'(TMO_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q <= DW'(TMO_DEF);
      dur_q <= DW'(DUR_DEF);
    end else begin
      if (tmo_we && wdata >= TMO_LO) tmo_q <= wdata;
      if (dur_we && wdata != '0)     dur_q <= wdata;
    end
  end
endmodule

// File: rtl/wdt_secs.sv
module wdt_secs
  import wdt_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TMO_DEF = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sec_tick,
  input  logic          st_we,
  input  logic          ping_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] tmo,
  output wdt_state_e    state_q,
  output logic [DW-1:0] left_q,
  output logic          expire
);
  logic go_run, go_stop, ping_ok;

  always_comb begin
    go_run  = st_we && wdata == DW'(WS_RUN);
    go_stop = st_we && wdata == DW'(WS_STOP);
    ping_ok = ping_we && wdata == '0 && state_q == WS_RUN;
    // host action in the same cycle outranks the final tick
    expire  = state_q == WS_RUN && sec_tick && left_q == DW'(1)
              && !go_run && !go_stop && !ping_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WS_INIT;
      left_q  <= DW'(TMO_DEF);
    end else if (go_run) begin
      state_q <= WS_RUN;
      left_q  <= tmo;
    end else if (go_stop) begin
      state_q <= WS_STOP;
    end else if (ping_ok) begin
      left_q  <= tmo;
    end else if (expire) begin
      state_q <= WS_STOP;
      left_q  <= '0;
    end else if (state_q == WS_RUN && sec_tick && left_q != '0) begin
      left_q  <= left_q - DW'(1);
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
  import wdt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ms_tick,
  input  logic [DW-1:0] dur,
  output logic          active_q,
  output logic [DW-1:0] cause_q
);
  logic [DW-1:0] ms_left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      ms_left_q <= '0;
      cause_q   <= CAUSE_POWER;
    end else if (start) begin
      active_q  <= 1'b1;
      ms_left_q <= dur;
      cause_q   <= CAUSE_EXPIRY;
    end else if (active_q && ms_tick) begin
      if (ms_left_q <= DW'(1)) active_q <= 1'b0;
      ms_left_q <= ms_left_q - DW'(1);
    end
  end
endmodule

// File: rtl/wdt_regcore.sv
module wdt_regcore
  import wdt_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int TMO_MIN = 3,
  parameter int TMO_DEF = 30,
  parameter int DUR_DEF = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sec_tick,
  input  logic          ms_tick,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          wdt_rst_o
);
  logic [DW-1:0] tmo_q, dur_q, left_q, cause_q;
  wdt_state_e    state_q;
  logic          expire;
  logic          we_tmo, we_dur, we_st, we_ping;
  logic [DW-1:0] rd_mux;

  always_comb begin
    we_tmo  = wr_en && addr == AW'(A_TMO);
    we_dur  = wr_en && addr == AW'(A_DUR);
    we_st   = wr_en && addr == AW'(A_STATE);
    we_ping = wr_en && addr == AW'(A_PING);
  end

  wdt_cfg #(.DW(DW), .TMO_MIN(TMO_MIN), .TMO_DEF(TMO_DEF), .DUR_DEF(DUR_DEF)) u_cfg (
    .clk(clk), .rst(rst), .tmo_we(we_tmo), .dur_we(we_dur),
    .wdata(wr_data), .tmo_q(tmo_q), .dur_q(dur_q)
  );

  wdt_secs #(.DW(DW), .TMO_DEF(TMO_DEF)) u_secs (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .st_we(we_st),
    .ping_we(we_ping), .wdata(wr_data), .tmo(tmo_q),
    .state_q(state_q), .left_q(left_q), .expire(expire)
  );

  wdt_pulse #(.DW(DW)) u_pulse (
    .clk(clk), .rst(rst), .start(expire), .ms_tick(ms_tick),
    .dur(dur_q), .active_q(wdt_rst_o), .cause_q(cause_q)
  );

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(A_CAUSE))      rd_mux = cause_q;
    else if (addr == AW'(A_STATE)) rd_mux = DW'(state_q);
    else if (addr == AW'(A_TMO))   rd_mux = tmo_q;
    else if (addr == AW'(A_LEFT))  rd_mux = left_q;
    else if (addr == AW'(A_DUR))   rd_mux = dur_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/wdt_regcore_chk.sv
module wdt_regcore_chk
  import wdt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sec_tick,
  input logic          ms_tick,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wr_data,
  input logic [1:0]    state_q,
  input logic [DW-1:0] left_q,
  input logic [DW-1:0] tmo_q,
  input logic [DW-1:0] cause_q,
  input logic          wdt_rst_o
);
  // R8
  expire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'(WS_RUN) && sec_tick && left_q == DW'(1) && !wr_en)
    |=> (wdt_rst_o && state_q == 2'(WS_STOP) && cause_q == CAUSE_EXPIRY && left_q == '0));

  // R6
  stop_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'(WS_STOP) && !wr_en) |=> $stable(left_q));

  // R9
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst_o && !ms_tick) |=> wdt_rst_o);

  // R3
  tmo_range_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_q >= DW'(3));

  // R10
  ping_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'(WS_RUN) && wr_en && addr == AW'(A_PING) && wr_data == '0)
    |=> (left_q == $past(tmo_q) && !$rose(wdt_rst_o)));

  // R5
  state_legal_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != 2'd3);
endmodule

bind wdt_regcore wdt_regcore_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .ms_tick(ms_tick),
  .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .state_q(state_q), .left_q(left_q), .tmo_q(tmo_q),
  .cause_q(cause_q), .wdt_rst_o(wdt_rst_o)
);

// File: tb/test_wdt_regcore.sv
`timescale 1ns/1ps
module test_wdt_regcore;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0, ms_tick = 1'b0;
  logic [7:0] addr = '0, wr_data = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       wdt_rst_o;

  int errs = 0, checks = 0, cyc = 0;
  logic rd_v = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  wdt_regcore i_wdt_regcore (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .ms_tick(ms_tick),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .wdt_rst_o(wdt_rst_o)
  );

  // monitor: one read result per strobe, compared against the scoreboard
  always @(posedge clk) rd_v <= rd_en;
  always @(negedge clk) begin
    if (rd_v && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errs++;
        $display("FAIL %s: got %0d expected %0d", t, rd_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errs++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic tick);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; sec_tick = tick;
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic sec1();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic ms1();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic chk_pulse(input logic e, input string t);
    checks++;
    if (wdt_rst_o !== e) begin
      errs++;
      $display("FAIL %s: got %0b expected %0b", t, wdt_rst_o, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk_pulse(1'b0, "R1 pulse low");
    rd_exp(8'h06, 8'd0,  "R1 state");
    rd_exp(8'h05, 8'd0,  "R1 cause");
    rd_exp(8'h07, 8'd30, "R1 timeout");
    rd_exp(8'h08, 8'd30, "R1 left");
    rd_exp(8'h0A, 8'd10, "R1 dur");
    // R2 ping and unmapped read as zero
    rd_exp(8'h09, 8'd0, "R2 ping reads 0");
    rd_exp(8'h33, 8'd0, "R2 unmapped");
    // R3 timeout range
    wr(8'h07, 8'd2, 1'b0);  rd_exp(8'h07, 8'd30,  "R3 reject 2");
    wr(8'h07, 8'd0, 1'b0);  rd_exp(8'h07, 8'd30,  "R3 reject 0");
    wr(8'h07, 8'd3, 1'b0);  rd_exp(8'h07, 8'd3,   "R3 accept 3");
    wr(8'h07, 8'd255, 1'b0); rd_exp(8'h07, 8'd255, "R3 accept 255");
    wr(8'h07, 8'd5, 1'b0);
    // R4 duration
    wr(8'h0A, 8'd0, 1'b0);  rd_exp(8'h0A, 8'd10, "R4 reject 0");
    wr(8'h0A, 8'd3, 1'b0);  rd_exp(8'h0A, 8'd3,  "R4 accept 3");
    // R6 ticks ignored while never configured
    sec1(); rd_exp(8'h08, 8'd30, "R6 init frozen");
    // R5 stop, frozen; illegal state ignored
    wr(8'h06, 8'd1, 1'b0); rd_exp(8'h06, 8'd1, "R5 stopped");
    sec1(); rd_exp(8'h08, 8'd30, "R6 stop frozen");
    wr(8'h06, 8'd3, 1'b0); rd_exp(8'h06, 8'd1, "R5 illegal ignored");
    // R5 arm loads timeout
    wr(8'h06, 8'd2, 1'b0); rd_exp(8'h06, 8'd2, "R5 running");
    rd_exp(8'h08, 8'd5, "R5 loaded");
    sec1(); rd_exp(8'h08, 8'd4, "R6 dec 1");
    sec1(); rd_exp(8'h08, 8'd3, "R6 dec 2");
    // R7 ping
    wr(8'h09, 8'd0, 1'b0); rd_exp(8'h08, 8'd5, "R7 ping reload");
    sec1();
    wr(8'h09, 8'd7, 1'b0); rd_exp(8'h08, 8'd4, "R7 nonzero ignored");
    // R10 ping in the same cycle as the last tick
    sec1(); sec1(); sec1();
    rd_exp(8'h08, 8'd1, "R10 at one");
    wr(8'h09, 8'd0, 1'b1);
    chk_pulse(1'b0, "R10 ping no pulse");
    rd_exp(8'h08, 8'd5, "R10 ping reloaded");
    rd_exp(8'h05, 8'd0, "R10 cause kept");
    // R8 normal expiry
    sec1(); sec1(); sec1(); sec1();
    sec1();
    chk_pulse(1'b1, "R8 pulse high");
    rd_exp(8'h06, 8'd1, "R8 state stop");
    rd_exp(8'h05, 8'd1, "R8 cause expiry");
    rd_exp(8'h08, 8'd0, "R8 left zero");
    // R4 change during pulse does not shorten it; R9 length
    wr(8'h0A, 8'd1, 1'b0);
    ms1(); chk_pulse(1'b1, "R9 after 1 ms");
    ms1(); chk_pulse(1'b1, "R9 after 2 ms");
    ms1(); chk_pulse(1'b0, "R9 after 3 ms");
    // R10 stop in the same cycle as the last tick
    wr(8'h0A, 8'd3, 1'b0);
    wr(8'h07, 8'd3, 1'b0);
    wr(8'h06, 8'd2, 1'b0);
    sec1(); sec1();
    wr(8'h06, 8'd1, 1'b1);
    chk_pulse(1'b0, "R10 stop no pulse");
    rd_exp(8'h06, 8'd1, "R10 stopped");
    rd_exp(8'h08, 8'd1, "R10 left kept");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule